// File: doc/BRIEF.md
# Two-Segment Automatic Frequency Ramp Generator

This block produces a stepped sequence of frequency-control words for a fractional-N synthesizer. Two programmable segments are chained. Each segment has a step count, a signed step size, a successor segment, an advance source and an optional snap back to the start word. A start strobe launches the sequence, but only while the ramp enable is set and manual mode is clear. From then on, every ramp clock adds the active segment's step to a 32-bit frequency word. The ramp clock is either every phase-detector tick or every second tick.

A segment can hand over to its successor in three ways: when its own step count runs out, or when one of two trigger detectors fires. Each detector watches a ramp-clock pin or a ramp-direction pin, and its edge polarity is selectable. The pins pass through a two-flop synchronizer first. A repeat counter can end a bounded pattern. When it does, the last word is held and busy drops. Clearing enable, or selecting manual mode, returns the block to idle at once.

The controller has three states: IDLE, RUN and HOLD. It has three named transitions:
- START takes IDLE or HOLD to RUN when the start strobe arrives while the block is active.
- BURST_END takes RUN to HOLD when the repeat limit is reached.
- ABORT takes any state to IDLE when enable is clear or manual mode is set.

Top module: `ramp_gen`

## Requirements
- R1: After reset, and whenever the block is in IDLE, busy is 0, freq_valid is 0 and freq_word is 0.
- R2: A cal_start pulse while cfg_enable=1 and cfg_manual=0 in IDLE or HOLD makes busy=1 and freq_valid=1 on the next cycle. It also loads freq_word with cfg_start_word and selects segment 0. A cal_start pulse while cfg_enable=0 or cfg_manual=1 has no effect.
- R3: In RUN, each ramp clock adds the active segment's 30-bit two's-complement step, sign-extended to 32 bits, to freq_word modulo 2^32. Without a ramp clock or an advance, freq_word is unchanged.
- R4: With cfg_half_rate=0, every pd_tick in RUN is a ramp clock. With cfg_half_rate=1, only the 2nd, 4th, 6th and later pd_tick since START are ramp clocks.
- R5: With advance code 0, a segment ends on its L-th ramp clock, where L is its 16-bit length. A length of 0 behaves as 1. The step count restarts in the next segment.
- R6: On an advance, the active segment becomes the finishing segment's successor bit (0 selects segment 0, 1 selects segment 1).
- R7: Advance code 1 ends the segment on a trigger A pulse, and code 2 ends it on a trigger B pulse, regardless of the ramp clock. Code 3 never ends it.
- R8: Trigger select codes are as follows:
  - 0 never fires.
  - 1 fires on a rising ramp_clk_in.
  - 2 fires on a rising ramp_dir_in.
  - 4 fires on every cycle.
  - 9 fires on a falling ramp_clk_in.
  - 10 fires on a falling ramp_dir_in.
  - Any other code never fires.

  A pin edge acts at the third rising clock edge after the pin changes.
- R9: When the segment being entered has its snap bit set, freq_word is loaded with the start word captured at START, in place of that cycle's step.
- R10: With a nonzero burst_limit N, the repeat counter advances on the selected event: source 0 is a segment advance, 1 is trigger A, 2 is trigger B and 3 is never. At the N-th event the block enters HOLD after that cycle's update. HOLD keeps busy=0, freq_valid=1 and a frozen freq_word.
- R11: With burst_limit=0, the pattern never enters HOLD.
- R12: cfg_enable=0 or cfg_manual=1 sends the block from any state to IDLE on the next cycle, with segment 0 selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_tick | input | 1 | Phase-detector rate tick |
| ramp_clk_in | input | 1 | Asynchronous ramp clock pin |
| ramp_dir_in | input | 1 | Asynchronous ramp direction pin |
| cfg_enable | input | 1 | Ramp enable |
| cfg_manual | input | 1 | Manual mode select (automatic mode when 0) |
| cal_start | input | 1 | Start strobe |
| cfg_half_rate | input | 1 | Ramp clock at half the tick rate |
| cfg_start_word | input | 32 | Initial frequency word |
| s0_len | input | 16 | Segment 0 length in ramp clocks |
| s0_inc | input | 30 | Segment 0 signed step |
| s0_next | input | 1 | Segment 0 successor |
| s0_adv | input | 2 | Segment 0 advance source |
| s0_snap | input | 1 | Snap to start word on entering segment 0 |
| s1_len | input | 16 | Segment 1 length in ramp clocks |
| s1_inc | input | 30 | Segment 1 signed step |
| s1_next | input | 1 | Segment 1 successor |
| s1_adv | input | 2 | Segment 1 advance source |
| s1_snap | input | 1 | Snap to start word on entering segment 1 |
| trig_a_sel | input | 4 | Trigger A source code |
| trig_b_sel | input | 4 | Trigger B source code |
| burst_limit | input | 13 | Repeat limit (0 = unbounded) |
| burst_src | input | 2 | Repeat counter event source |
| freq_word | output | 32 | Accumulated frequency word |
| freq_valid | output | 1 | Frequency word is meaningful |
| busy | output | 1 | Ramp in progress |

## Verification
The assertions check several rules on every cycle:
- The idle output is quiet.
- START loads the start word.
- ABORT clears the outputs after any cycle in which the block is inactive.
- HOLD keeps the word frozen.
- In RUN, the word does not move in a cycle with no tick and no trigger.

The exact arithmetic of the word needs the bench's reference model, compared on every clock, across the bench's scenarios. That covers signed steps, timeout lengths, half-rate spacing, successor choice, snap-back, each trigger code against real pin edges, and the cycle at which a burst ends.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    parameter int RP_WORD_W  = 32;
    parameter int RP_INC_W   = 30;
    parameter int RP_LEN_W   = 16;
    parameter int RP_BURST_W = 13;
    parameter int RP_SYNC_N  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } ramp_state_e;

    localparam logic [1:0] ADV_TIMEOUT = 2'd0;
    localparam logic [1:0] ADV_TRIG_A  = 2'd1;
    localparam logic [1:0] ADV_TRIG_B  = 2'd2;

    localparam logic [3:0] TRG_CLK_RISE = 4'd1;
    localparam logic [3:0] TRG_DIR_RISE = 4'd2;
    localparam logic [3:0] TRG_ALWAYS   = 4'd4;
    localparam logic [3:0] TRG_CLK_FALL = 4'd9;
    localparam logic [3:0] TRG_DIR_FALL = 4'd10;

    function automatic logic trig_fire(input logic [3:0] code,
                                       input logic ck_now, input logic ck_old,
                                       input logic dr_now, input logic dr_old);
        logic hit;
        unique case (code)
            TRG_CLK_RISE: hit = ck_now & ~ck_old;
            TRG_DIR_RISE: hit = dr_now & ~dr_old;
            TRG_ALWAYS:   hit = 1'b1;
            TRG_CLK_FALL: hit = ~ck_now & ck_old;
            TRG_DIR_FALL: hit = ~dr_now & dr_old;
            default:      hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ramp_trig_det.sv
module ramp_trig_det
    import ramp_pkg::*;
#(
    parameter int SYNC_N = RP_SYNC_N
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_clk,
    input  logic       pin_dir,
    input  logic [3:0] sel_a,
    input  logic [3:0] sel_b,
    output logic       trig_a,
    output logic       trig_b
);
    localparam int DEPTH = SYNC_N + 1;

    logic [1:0] pins;
    logic [1:0] now_v;
    logic [1:0] old_v;

    assign pins = {pin_dir, pin_clk};

    for (genvar p = 0; p < 2; p++) begin : g_pin
        logic [DEPTH-1:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[DEPTH-2:0], pins[p]};
        end
        assign now_v[p] = sh[SYNC_N-1];
        assign old_v[p] = sh[SYNC_N];
    end

    assign trig_a = trig_fire(sel_a, now_v[0], old_v[0], now_v[1], old_v[1]);
    assign trig_b = trig_fire(sel_b, now_v[0], old_v[0], now_v[1], old_v[1]);

endmodule

// File: rtl/ramp_rate_div.sv
module ramp_rate_div (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pd_tick,
    input  logic half,
    output logic step
);
    logic phase;

    always_ff @(posedge clk) begin
        if (!rst_n || !run)     phase <= 1'b0;
        else if (pd_tick && half) phase <= ~phase;
    end

    assign step = run & pd_tick & (~half | phase);

endmodule

// File: rtl/ramp_gen.sv
module ramp_gen
    import ramp_pkg::*;
#(
    parameter int WORD_W  = RP_WORD_W,
    parameter int INC_W   = RP_INC_W,
    parameter int LEN_W   = RP_LEN_W,
    parameter int BURST_W = RP_BURST_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_tick,
    input  logic               ramp_clk_in,
    input  logic               ramp_dir_in,
    input  logic               cfg_enable,
    input  logic               cfg_manual,
    input  logic               cal_start,
    input  logic               cfg_half_rate,
    input  logic [WORD_W-1:0]  cfg_start_word,
    input  logic [LEN_W-1:0]   s0_len,
    input  logic [INC_W-1:0]   s0_inc,
    input  logic               s0_next,
    input  logic [1:0]         s0_adv,
    input  logic               s0_snap,
    input  logic [LEN_W-1:0]   s1_len,
    input  logic [INC_W-1:0]   s1_inc,
    input  logic               s1_next,
    input  logic [1:0]         s1_adv,
    input  logic               s1_snap,
    input  logic [3:0]         trig_a_sel,
    input  logic [3:0]         trig_b_sel,
    input  logic [BURST_W-1:0] burst_limit,
    input  logic [1:0]         burst_src,
    output logic [WORD_W-1:0]  freq_word,
    output logic               freq_valid,
    output logic               busy
);
    localparam int EXT_W = WORD_W - INC_W;

    ramp_state_e state, state_nxt;

    logic [WORD_W-1:0]  freq_q, base_q;
    logic               seg_q;
    logic [LEN_W-1:0]   cnt_q;
    logic [BURST_W-1:0] bcnt_q;

    logic active, running, step, trig_a, trig_b;
    logic [LEN_W-1:0] len_sel;
    logic [INC_W-1:0] inc_sel;
    logic [1:0]       adv_sel;
    logic             nxt_sel, snap_tgt;
    logic [WORD_W-1:0] inc_ext, freq_stepped, freq_nxt;
    logic [LEN_W:0]     cnt_plus;
    logic [BURST_W:0]   bcnt_plus;
    logic timeout, advance, bump, burst_done;

    assign active  = cfg_enable & ~cfg_manual;
    assign running = (state == ST_RUN);

    ramp_trig_det u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_clk (ramp_clk_in),
        .pin_dir (ramp_dir_in),
        .sel_a   (trig_a_sel),
        .sel_b   (trig_b_sel),
        .trig_a  (trig_a),
        .trig_b  (trig_b)
    );

    ramp_rate_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .pd_tick (pd_tick),
        .half    (cfg_half_rate),
        .step    (step)
    );

    // Active segment fields
    always_comb begin
        len_sel  = seg_q ? s1_len  : s0_len;
        inc_sel  = seg_q ? s1_inc  : s0_inc;
        adv_sel  = seg_q ? s1_adv  : s0_adv;
        nxt_sel  = seg_q ? s1_next : s0_next;
        snap_tgt = nxt_sel ? s1_snap : s0_snap;
    end

    assign inc_ext      = {{EXT_W{inc_sel[INC_W-1]}}, inc_sel};
    assign cnt_plus     = {1'b0, cnt_q} + {{LEN_W{1'b0}}, 1'b1};
    assign bcnt_plus    = {1'b0, bcnt_q} + {{BURST_W{1'b0}}, 1'b1};
    assign timeout      = step && (cnt_plus >= {1'b0, len_sel});
    assign freq_stepped = step ? freq_q + inc_ext : freq_q;

    always_comb begin
        unique case (adv_sel)
            ADV_TIMEOUT: advance = timeout;
            ADV_TRIG_A:  advance = trig_a;
            ADV_TRIG_B:  advance = trig_b;
            default:     advance = 1'b0;
        endcase
        unique case (burst_src)
            2'd0:    bump = advance;
            2'd1:    bump = trig_a;
            2'd2:    bump = trig_b;
            default: bump = 1'b0;
        endcase
        freq_nxt   = (advance && snap_tgt) ? base_q : freq_stepped;
        burst_done = bump && (burst_limit != '0) && (bcnt_plus == {1'b0, burst_limit});
    end

    // Next state: START, BURST_END, ABORT
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_HOLD: if (cal_start) state_nxt = ST_RUN;
            ST_RUN:           if (burst_done) state_nxt = ST_HOLD;
            default:          state_nxt = ST_IDLE;
        endcase
        if (!active) state_nxt = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            freq_q <= '0;
            base_q <= '0;
            seg_q  <= 1'b0;
            cnt_q  <= '0;
            bcnt_q <= '0;
        end else if (!running) begin
            if (cal_start) begin
                freq_q <= cfg_start_word;
                base_q <= cfg_start_word;
                seg_q  <= 1'b0;
                cnt_q  <= '0;
                bcnt_q <= '0;
            end
        end else begin
            freq_q <= freq_nxt;
            if (advance) begin
                seg_q <= nxt_sel;
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_plus[LEN_W-1:0];
            end
            if (bump) bcnt_q <= bcnt_plus[BURST_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        busy       = (state == ST_RUN);
        freq_valid = (state != ST_IDLE);
        freq_word  = freq_q;
    end

endmodule

// File: rtl/ramp_gen_chk.sv
module ramp_gen_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd_tick,
    input logic              cfg_enable,
    input logic              cfg_manual,
    input logic              cal_start,
    input logic [WORD_W-1:0] cfg_start_word,
    input logic              trig_a,
    input logic              trig_b,
    input logic [WORD_W-1:0] freq_word,
    input logic              freq_valid,
    input logic              busy
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !freq_valid) |-> freq_word == '0);                                   // R1

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_start && cfg_enable && !cfg_manual && !busy)
        |=> (busy && freq_valid && freq_word == $past(cfg_start_word)));               // R2

    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pd_tick && !trig_a && !trig_b && cfg_enable && !cfg_manual)
        |=> (busy && $stable(freq_word)));                                             // R3

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && freq_valid && !cal_start && cfg_enable && !cfg_manual)
        |=> (!busy && freq_valid && $stable(freq_word)));                              // R10

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable || cfg_manual) |=> (!busy && !freq_valid && freq_word == '0));    // R12
endmodule

bind ramp_gen ramp_gen_chk #(.WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pd_tick        (pd_tick),
    .cfg_enable     (cfg_enable),
    .cfg_manual     (cfg_manual),
    .cal_start      (cal_start),
    .cfg_start_word (cfg_start_word),
    .trig_a         (trig_a),
    .trig_b         (trig_b),
    .freq_word      (freq_word),
    .freq_valid     (freq_valid),
    .busy           (busy)
);

// File: tb/ramp_gen_bench.sv
module ramp_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_tick = 1'b0;
    logic        ramp_clk_in = 1'b0, ramp_dir_in = 1'b0;
    logic        cfg_enable = 1'b0, cfg_manual = 1'b0, cal_start = 1'b0, cfg_half_rate = 1'b0;
    logic [31:0] cfg_start_word = '0;
    logic [15:0] s0_len = '0, s1_len = '0;
    logic [29:0] s0_inc = '0, s1_inc = '0;
    logic        s0_next = 1'b0, s1_next = 1'b0, s0_snap = 1'b0, s1_snap = 1'b0;
    logic [1:0]  s0_adv = '0, s1_adv = '0, burst_src = '0;
    logic [3:0]  trig_a_sel = '0, trig_b_sel = '0;
    logic [12:0] burst_limit = '0;
    logic [31:0] freq_word;
    logic        freq_valid, busy;

    int    checks = 0, errors = 0, tick_mode = 0, cyc = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #5 clk = ~clk;

    ramp_gen u_ramp_gen (.*);

    // Reference model state
    int          m_state = 0;  // 0 idle, 1 run, 2 hold
    int          m_seg = 0, m_cnt = 0, m_bcnt = 0;
    bit          m_phase = 0;
    logic [31:0] m_freq = '0, m_base = '0;
    bit          c1 = 0, c2 = 0, c3 = 0, d1 = 0, d2 = 0, d3 = 0;

    function automatic bit fire(logic [3:0] code, bit ck, bit ckp, bit dr, bit drp);
        case (code)
            4'd1:  return ck && !ckp;
            4'd2:  return dr && !drp;
            4'd4:  return 1'b1;
            4'd9:  return !ck && ckp;
            4'd10: return !dr && drp;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit ta, tb, stp, adv, bmp, snap_n;
        int len, nxt, code;
        logic [29:0] inc;
        if (!rst_n) begin
            m_state = 0; m_seg = 0; m_cnt = 0; m_bcnt = 0; m_phase = 0;
            m_freq = '0; m_base = '0;
            c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0; d3 = 0;
        end else begin
            ta = fire(trig_a_sel, c2, c3, d2, d3);
            tb = fire(trig_b_sel, c2, c3, d2, d3);
            if (!cfg_enable || cfg_manual) begin
                m_state = 0; m_seg = 0; m_cnt = 0; m_bcnt = 0; m_phase = 0; m_freq = '0; m_base = '0;
            end else if (m_state != 1) begin
                if (cal_start) begin
                    m_state = 1; m_seg = 0; m_cnt = 0; m_bcnt = 0; m_phase = 0;
                    m_freq = cfg_start_word; m_base = cfg_start_word;
                end
            end else begin
                stp = pd_tick && (!cfg_half_rate || m_phase);
                if (pd_tick && cfg_half_rate) m_phase = !m_phase;
                len  = (m_seg == 1) ? int'(s1_len) : int'(s0_len);
                inc  = (m_seg == 1) ? s1_inc : s0_inc;
                nxt  = (m_seg == 1) ? int'(s1_next) : int'(s0_next);
                code = (m_seg == 1) ? int'(s1_adv) : int'(s0_adv);
                if (stp) m_freq = m_freq + {{2{inc[29]}}, inc};
                case (code)
                    0: adv = stp && (m_cnt + 1 >= len);
                    1: adv = ta;
                    2: adv = tb;
                    default: adv = 0;
                endcase
                if (stp) m_cnt++;
                if (adv) begin
                    m_seg = nxt; m_cnt = 0;
                    snap_n = (nxt == 1) ? s1_snap : s0_snap;
                    if (snap_n) m_freq = m_base;
                end
                case (burst_src)
                    2'd0: bmp = adv;
                    2'd1: bmp = ta;
                    2'd2: bmp = tb;
                    default: bmp = 0;
                endcase
                if (bmp) begin
                    m_bcnt++;
                    if (burst_limit != 0 && m_bcnt == int'(burst_limit)) m_state = 2;
                end
            end
            c3 = c2; c2 = c1; c1 = ramp_clk_in;
            d3 = d2; d2 = d1; d1 = ramp_dir_in;
        end
    end

    task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual busy/valid/word=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(cur_req, {busy, freq_valid, freq_word},
                {m_state == 1, m_state != 0, m_freq});
            cyc++;
            case (tick_mode)
                0: pd_tick = 1'b1;
                1: pd_tick = (cyc % 2) == 0;
                default: pd_tick = (cyc % 3) == 0;
            endcase
        end
    endtask

    task automatic go();
        cal_start = 1'b1; cycle(1); cal_start = 1'b0;
    endtask

    task automatic abort();
        cfg_enable = 1'b0; cycle(2); cfg_enable = 1'b1;
    endtask

    task automatic toggles(int n, int gap);
        for (int i = 0; i < n; i++) begin
            if (i % 2 == 0) ramp_clk_in = ~ramp_clk_in;
            else            ramp_dir_in = ~ramp_dir_in;
            cycle(gap);
        end
    endtask

    initial begin
        cycle(3);
        rst_n = 1'b1;
        cycle(1);
        cur_req = "R1";
        chk("R1", {busy, freq_valid, freq_word}, 34'd0);

        // R2: start ignored while disabled or manual, accepted when active
        cur_req = "R2";
        cfg_start_word = 32'h1000_0000;
        go();
        chk("R2", {busy, freq_valid, freq_word}, 34'd0);
        cfg_enable = 1'b1; cfg_manual = 1'b1;
        go();
        chk("R2", {busy, freq_valid, freq_word}, 34'd0);
        cfg_manual = 1'b0;
        s0_len = 16'd3; s0_inc = 30'd5; s0_next = 1'b1; s0_adv = 2'd0;
        s1_len = 16'd2; s1_inc = 30'h3FFF_FFFD; s1_next = 1'b0; s1_adv = 2'd0;
        go();
        chk("R2", {busy, freq_valid, freq_word}, {2'b11, 32'h1000_0000});

        // R3 R5 R6 R11: timeout chaining with signed steps, unbounded
        cur_req = "R3_R5_R6_R11";
        cycle(40);
        chk("R11", {32'd0, busy, freq_valid}, {32'd0, 2'b11});

        // R5: zero length behaves as one
        cur_req = "R5";
        abort(); s0_len = 16'd0; s1_len = 16'd1; cfg_start_word = 32'hFFFF_FFF0;
        go(); cycle(20);

        // R4: half-rate ramp clock with sparse ticks
        cur_req = "R4";
        abort(); s0_len = 16'd4; s1_len = 16'd3; cfg_half_rate = 1'b1; tick_mode = 1;
        go(); cycle(40);
        tick_mode = 2; cycle(30);
        cfg_half_rate = 1'b0;

        // R7 R8: trigger-driven advance, each code
        cur_req = "R7_R8";
        abort(); s0_adv = 2'd1; s1_adv = 2'd2; trig_a_sel = 4'd1; trig_b_sel = 4'd10;
        go(); toggles(12, 5);
        trig_a_sel = 4'd9; trig_b_sel = 4'd2; toggles(12, 4);
        trig_a_sel = 4'd4; trig_b_sel = 4'd5; cycle(10);
        trig_a_sel = 4'd0; trig_b_sel = 4'd15; toggles(8, 3);
        s0_adv = 2'd3; s1_adv = 2'd3; trig_a_sel = 4'd4; cycle(10);

        // R9: snap back on entering segment 1, then segment 0
        cur_req = "R9";
        abort(); s0_adv = 2'd0; s1_adv = 2'd0; s1_snap = 1'b1; tick_mode = 0;
        go(); cycle(25);
        s0_snap = 1'b1; s1_snap = 1'b0; cycle(25);
        s0_snap = 1'b0;

        // R10: bounded bursts from each source
        cur_req = "R10";
        abort(); burst_limit = 13'd3; burst_src = 2'd0;
        go(); cycle(30);
        chk("R10", {32'd0, busy, freq_valid}, {32'd0, 2'b01});
        go(); cycle(30);
        burst_src = 2'd1; trig_a_sel = 4'd4; burst_limit = 13'd5;
        go(); cycle(12);
        chk("R10", {32'd0, busy, freq_valid}, {32'd0, 2'b01});
        burst_src = 2'd2; trig_b_sel = 4'd1; trig_a_sel = 4'd0; burst_limit = 13'd2;
        go(); toggles(10, 4);
        burst_src = 2'd3; go(); cycle(30);
        chk("R10", {32'd0, busy, freq_valid}, {32'd0, 2'b11});

        // R12: manual and disable abort mid-run
        cur_req = "R12";
        cfg_manual = 1'b1; cycle(3);
        chk("R12", {busy, freq_valid, freq_word}, 34'd0);
        cfg_manual = 1'b0; burst_limit = 13'd0; go(); cycle(7);
        cfg_enable = 1'b0; cycle(2);
        chk("R12", {busy, freq_valid, freq_word}, 34'd0);
        cfg_enable = 1'b1; go(); cycle(5);
        chk("R12", {busy, freq_valid, freq_word}, {2'b11, m_freq});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule